// File: doc/BRIEF.md
# Watchdog recovery and reset controller

This block sits next to the divider logic of a programmable clock synthesizer. It owns the live feedback (M) and output (N) divider settings and two backup copies. Software can write the N backup at any time. The M backup cannot be reached by software: it captures the live M value by itself at the moment the watchdog enable bit goes from 0 to 1. When the external watchdog counter signals a timeout, the block looks at the recovery mode field. In manual mode it reloads both live dividers from their backups. In every other mode it leaves the dividers alone. In both cases it drives an active-low system reset pulse.

Software can also ask for the same reset pulse by setting a request bit in the control register. The pulse does not start when the bit is written. It starts when the bus transaction that carried the write is flagged as finished. Both sources share one pulse-width counter, so the two pulses are always the same length. Any request that arrives while a pulse is already running joins that pulse and does not lengthen it. The request bit clears itself at the edge where the pulse it joined ends.

Top module: `wdt_recovery_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `m_active` equals `M_INIT`, `n_active` equals `N_INIT`, `srst_n` is 1 and `sw_rst_bit` is 0. The hidden M backup, the N backup, the enable bit, the mode field (00) and the request bit all start from these defaults.
- R2: A pulse on `m_wr` or `n_wr` loads `m_wdata` or `n_wdata` into the live divider, and the new value is visible one cycle later.
- R3: A `ctl_wr` with `ctl_wd_en`=1 while the stored enable bit is 0 copies the live M value from before that edge into the hidden M backup. A further write with `ctl_wd_en`=1 while the bit is already 1 does not copy again.
- R4: When the stored mode is 01 (manual) and `wd_timeout` starts a pulse, `m_active` takes the hidden M backup and `n_active` takes the N backup at the same edge where `srst_n` falls.
- R5: When the stored mode is 00, 10 or 11, a timeout only produces the reset pulse. `m_active` and `n_active` keep their values.
- R6: A timeout that finds no pulse running drives `srst_n` low from the next edge for exactly `PULSE_LEN` cycles.
- R7: `ctl_wr` with `ctl_sw_rst`=1 sets `sw_rst_bit`, but no pulse begins until a cycle in which `xact_end` is 1. That cycle may be the same cycle as the write or any later cycle.
- R8: A pulse started by a software request is low for exactly `PULSE_LEN` cycles, the same as a timeout pulse.
- R9: `sw_rst_bit` returns to 0 at the same edge where the pulse that served the request ends and `srst_n` goes back to 1.
- R10: A timeout or software trigger that arrives while `srst_n` is low joins the running pulse. It does not lengthen the pulse and does not restore the dividers.
- R11: If a restore and a write to `m_wr`/`n_wr` fall on the same edge, the restore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_timeout | input | 1 | One-cycle strobe from the watchdog counter |
| m_wr | input | 1 | Write strobe for the live M divider |
| m_wdata | input | M_W | Data for the live M divider |
| n_wr | input | 1 | Write strobe for the live N divider |
| n_wdata | input | N_W | Data for the live N divider |
| nrec_wr | input | 1 | Write strobe for the N backup register |
| nrec_wdata | input | N_W | Data for the N backup register |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wd_en | input | 1 | Watchdog enable value in the control write |
| ctl_rec_mode | input | 2 | Recovery mode: 00 none, 01 manual, 10 and 11 treated as none |
| ctl_sw_rst | input | 1 | 1 requests a software reset |
| xact_end | input | 1 | Marks the last cycle of a bus write transaction |
| m_active | output | M_W | Live M divider value |
| n_active | output | N_W | Live N divider value |
| srst_n | output | 1 | Active-low system reset pulse |
| sw_rst_bit | output | 1 | Current state of the software reset request bit |

## Verification
On every cycle, the bound checker confirms the following. Each low period of `srst_n` lasts exactly `PULSE_LEN` samples and never longer, even when requests are merged. Each falling edge has a timeout or a completed software request behind it. A manual-mode timeout loads both backups. A timeout in any other mode leaves the dividers unchanged. The request bit drops only together with the rising edge of `srst_n`. Some behaviours need ordered stimulus and can only be shown by the bench scenarios: that the hidden M copy is taken only on the 0-to-1 change of the enable bit, that a request waits across idle cycles for `xact_end`, and that a restore beats a divider write on the same edge. The bench's reference model tracks all of these and is compared against the outputs on every cycle.

// File: rtl/wdt_rec_pkg.sv
package wdt_rec_pkg;

    typedef enum logic [1:0] {
        REC_NONE   = 2'b00,
        REC_MANUAL = 2'b01,
        REC_RSV_A  = 2'b10,
        REC_RSV_B  = 2'b11
    } rec_mode_e;

    function automatic logic is_manual(input rec_mode_e mode);
        return mode == REC_MANUAL;
    endfunction

endpackage

// File: rtl/wdt_rec_pulse.sv
module wdt_rec_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy,
    output logic start,
    output logic last
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = trig && !st_q.busy;
        last  = st_q.busy && (st_q.cnt == '0);
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(PULSE_LEN - 1);
        end else if (st_q.busy) begin
            if (last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/wdt_rec_swreq.sv
module wdt_rec_swreq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic xact_end,
    input  logic pulse_last,
    output logic fire,
    output logic sw_bit
);
    typedef struct packed {
        logic req;
        logic served;
    } swreq_t;

    swreq_t st_d, st_q;

    always_comb begin
        fire      = xact_end && (st_q.req || set_req);
        st_d.req    = st_q.req || set_req;
        st_d.served = st_q.served || fire;
        if (pulse_last && st_d.served) begin
            st_d.req    = 1'b0;
            st_d.served = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_bit = st_q.req;

endmodule

// File: rtl/wdt_rec_regs.sv
module wdt_rec_regs
    import wdt_rec_pkg::*;
#(
    parameter int              M_W    = 9,
    parameter int              N_W    = 8,
    parameter logic [M_W-1:0]  M_INIT = 9'd60,
    parameter logic [N_W-1:0]  N_INIT = 8'd100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           m_wr,
    input  logic [M_W-1:0] m_wdata,
    input  logic           n_wr,
    input  logic [N_W-1:0] n_wdata,
    input  logic           nrec_wr,
    input  logic [N_W-1:0] nrec_wdata,
    input  logic           ctl_wr,
    input  logic           ctl_wd_en,
    input  logic [1:0]     ctl_rec_mode,
    input  logic           restore,
    output logic [M_W-1:0] m_act,
    output logic [N_W-1:0] n_act,
    output logic [M_W-1:0] m_rec,
    output logic [N_W-1:0] n_rec,
    output logic           wd_en,
    output rec_mode_e      mode
);
    typedef struct packed {
        logic [M_W-1:0] m_act;
        logic [N_W-1:0] n_act;
        logic [M_W-1:0] m_rec;
        logic [N_W-1:0] n_rec;
        logic           wd_en;
        rec_mode_e      mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (m_wr)    st_d.m_act = m_wdata;
        if (n_wr)    st_d.n_act = n_wdata;
        if (nrec_wr) st_d.n_rec = nrec_wdata;
        if (ctl_wr) begin
            st_d.wd_en = ctl_wd_en;
            st_d.mode  = rec_mode_e'(ctl_rec_mode);
            if (ctl_wd_en && !st_q.wd_en) begin
                st_d.m_rec = st_q.m_act;
            end
        end
        if (restore) begin
            st_d.m_act = st_q.m_rec;
            st_d.n_act = st_q.n_rec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.m_act <= M_INIT;
            st_q.n_act <= N_INIT;
            st_q.m_rec <= M_INIT;
            st_q.n_rec <= N_INIT;
            st_q.wd_en <= 1'b0;
            st_q.mode  <= REC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_act = st_q.m_act;
    assign n_act = st_q.n_act;
    assign m_rec = st_q.m_rec;
    assign n_rec = st_q.n_rec;
    assign wd_en = st_q.wd_en;
    assign mode  = st_q.mode;

endmodule

// File: rtl/wdt_recovery_ctrl.sv
module wdt_recovery_ctrl
    import wdt_rec_pkg::*;
#(
    parameter int              M_W       = 9,
    parameter int              N_W       = 8,
    parameter int              PULSE_LEN = 16,
    parameter logic [M_W-1:0]  M_INIT    = 9'd60,
    parameter logic [N_W-1:0]  N_INIT    = 8'd100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wd_timeout,
    input  logic           m_wr,
    input  logic [M_W-1:0] m_wdata,
    input  logic           n_wr,
    input  logic [N_W-1:0] n_wdata,
    input  logic           nrec_wr,
    input  logic [N_W-1:0] nrec_wdata,
    input  logic           ctl_wr,
    input  logic           ctl_wd_en,
    input  logic [1:0]     ctl_rec_mode,
    input  logic           ctl_sw_rst,
    input  logic           xact_end,
    output logic [M_W-1:0] m_active,
    output logic [N_W-1:0] n_active,
    output logic           srst_n,
    output logic           sw_rst_bit
);
    logic           sw_fire;
    logic           pulse_busy;
    logic           pulse_start;
    logic           pulse_last;
    logic           restore;
    logic [M_W-1:0] m_rec;
    logic [N_W-1:0] n_rec;
    logic           wd_en;
    rec_mode_e      mode;

    wdt_rec_swreq u_swreq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (ctl_wr && ctl_sw_rst),
        .xact_end   (xact_end),
        .pulse_last (pulse_last),
        .fire       (sw_fire),
        .sw_bit     (sw_rst_bit)
    );

    wdt_rec_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (wd_timeout || sw_fire),
        .busy  (pulse_busy),
        .start (pulse_start),
        .last  (pulse_last)
    );

    assign restore = pulse_start && wd_timeout && is_manual(mode);

    wdt_rec_regs #(
        .M_W    (M_W),
        .N_W    (N_W),
        .M_INIT (M_INIT),
        .N_INIT (N_INIT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .m_wr         (m_wr),
        .m_wdata      (m_wdata),
        .n_wr         (n_wr),
        .n_wdata      (n_wdata),
        .nrec_wr      (nrec_wr),
        .nrec_wdata   (nrec_wdata),
        .ctl_wr       (ctl_wr),
        .ctl_wd_en    (ctl_wd_en),
        .ctl_rec_mode (ctl_rec_mode),
        .restore      (restore),
        .m_act        (m_active),
        .n_act        (n_active),
        .m_rec        (m_rec),
        .n_rec        (n_rec),
        .wd_en        (wd_en),
        .mode         (mode)
    );

    assign srst_n = !pulse_busy;

endmodule

// File: rtl/wdt_rec_chk.sv
module wdt_rec_chk #(
    parameter int M_W       = 9,
    parameter int N_W       = 8,
    parameter int PULSE_LEN = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wd_timeout,
    input logic           xact_end,
    input logic           ctl_wr,
    input logic           ctl_wd_en,
    input logic           ctl_sw_rst,
    input logic           m_wr,
    input logic           n_wr,
    input logic           srst_n,
    input logic           sw_rst_bit,
    input logic [M_W-1:0] m_active,
    input logic [N_W-1:0] n_active,
    input logic [M_W-1:0] m_rec,
    input logic [N_W-1:0] n_rec,
    input logic           wd_en,
    input logic [1:0]     mode
);
    localparam int LW = $clog2(PULSE_LEN + 2);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!srst_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assert_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr && ctl_wd_en && !wd_en) |-> (m_rec == $past(m_active)));

    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(srst_n) && $past(wd_timeout) && ($past(mode) == 2'b01))
        |-> (m_active == $past(m_rec) && n_active == $past(n_rec)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(srst_n) && $past(wd_timeout) && ($past(mode) != 2'b01)
         && !$past(m_wr) && !$past(n_wr))
        |-> ($stable(m_active) && $stable(n_active)));

    assert_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_n) |-> (low_cnt == LW'(PULSE_LEN)));

    assert_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_n) |->
        $past(wd_timeout || (xact_end && (sw_rst_bit || (ctl_wr && ctl_sw_rst)))));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rst_bit) |-> $rose(srst_n));

    assert_no_extend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_n |-> (low_cnt < LW'(PULSE_LEN)));

endmodule

bind wdt_recovery_ctrl wdt_rec_chk #(
    .M_W       (M_W),
    .N_W       (N_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wd_timeout (wd_timeout),
    .xact_end   (xact_end),
    .ctl_wr     (ctl_wr),
    .ctl_wd_en  (ctl_wd_en),
    .ctl_sw_rst (ctl_sw_rst),
    .m_wr       (m_wr),
    .n_wr       (n_wr),
    .srst_n     (srst_n),
    .sw_rst_bit (sw_rst_bit),
    .m_active   (m_active),
    .n_active   (n_active),
    .m_rec      (m_rec),
    .n_rec      (n_rec),
    .wd_en      (wd_en),
    .mode       (mode)
);

// File: tb/wdt_recovery_ctrl_tb.sv
module wdt_recovery_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int M_W        = 9;
    localparam int N_W        = 8;
    localparam int PULSE_LEN  = 16;
    localparam int M_INIT     = 60;
    localparam int N_INIT     = 100;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wd_timeout = 1'b0;
    logic           m_wr = 1'b0;
    logic [M_W-1:0] m_wdata = '0;
    logic           n_wr = 1'b0;
    logic [N_W-1:0] n_wdata = '0;
    logic           nrec_wr = 1'b0;
    logic [N_W-1:0] nrec_wdata = '0;
    logic           ctl_wr = 1'b0;
    logic           ctl_wd_en = 1'b0;
    logic [1:0]     ctl_rec_mode = 2'b00;
    logic           ctl_sw_rst = 1'b0;
    logic           xact_end = 1'b0;
    logic [M_W-1:0] m_active;
    logic [N_W-1:0] n_active;
    logic           srst_n;
    logic           sw_rst_bit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_recovery_ctrl #(
        .M_W       (M_W),
        .N_W       (N_W),
        .PULSE_LEN (PULSE_LEN),
        .M_INIT    (M_W'(M_INIT)),
        .N_INIT    (N_W'(N_INIT))
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wd_timeout   (wd_timeout),
        .m_wr         (m_wr),
        .m_wdata      (m_wdata),
        .n_wr         (n_wr),
        .n_wdata      (n_wdata),
        .nrec_wr      (nrec_wr),
        .nrec_wdata   (nrec_wdata),
        .ctl_wr       (ctl_wr),
        .ctl_wd_en    (ctl_wd_en),
        .ctl_rec_mode (ctl_rec_mode),
        .ctl_sw_rst   (ctl_sw_rst),
        .xact_end     (xact_end),
        .m_active     (m_active),
        .n_active     (n_active),
        .srst_n       (srst_n),
        .sw_rst_bit   (sw_rst_bit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model: integer state, one update per rising edge.
    int e_m, e_n, e_mrec, e_nrec, e_mode, e_rem;
    bit e_en, e_sw, e_served;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_m = M_INIT; e_n = N_INIT; e_mrec = M_INIT; e_nrec = N_INIT;
            e_mode = 0; e_rem = 0; e_en = 0; e_sw = 0; e_served = 0;
        end else begin
            bit sw_go, go, at_end, nsw, nserved;
            int nm, nn, nmrec;
            sw_go   = xact_end && (e_sw || (ctl_wr && ctl_sw_rst));
            go      = (wd_timeout || sw_go) && (e_rem == 0);
            at_end  = (e_rem == 1);
            nsw     = e_sw || (ctl_wr && ctl_sw_rst);
            nserved = e_served || sw_go;
            if (at_end && nserved) begin nsw = 0; nserved = 0; end
            nm = m_wr ? int'(m_wdata) : e_m;
            nn = n_wr ? int'(n_wdata) : e_n;
            nmrec = (ctl_wr && ctl_wd_en && !e_en) ? e_m : e_mrec;
            if (go && wd_timeout && e_mode == 1) begin nm = e_mrec; nn = e_nrec; end
            if (nrec_wr) e_nrec = int'(nrec_wdata);
            if (ctl_wr) begin e_en = ctl_wd_en; e_mode = int'(ctl_rec_mode); end
            e_rem = go ? PULSE_LEN : ((e_rem > 0) ? e_rem - 1 : 0);
            e_m = nm; e_n = nn; e_mrec = nmrec; e_sw = nsw; e_served = nserved;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R4/R5/R11 model m_active", int'(m_active), e_m);
            chk("R2/R4/R5/R11 model n_active", int'(n_active), e_n);
            chk("R6/R8/R10 model srst_n", int'(srst_n), (e_rem == 0) ? 1 : 0);
            chk("R7/R9 model sw_rst_bit", int'(sw_rst_bit), int'(e_sw));
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_in();
        wd_timeout = 0; m_wr = 0; n_wr = 0; nrec_wr = 0;
        ctl_wr = 0; ctl_sw_rst = 0; xact_end = 0;
    endtask

    task automatic wr_m(input int v);
        m_wr = 1; m_wdata = M_W'(v); cyc(); clear_in();
    endtask

    task automatic wr_n(input int v);
        n_wr = 1; n_wdata = N_W'(v); cyc(); clear_in();
    endtask

    task automatic wr_nrec(input int v);
        nrec_wr = 1; nrec_wdata = N_W'(v); cyc(); clear_in();
    endtask

    task automatic wr_ctl(input bit en, input int mode, input bit sw);
        ctl_wr = 1; ctl_wd_en = en; ctl_rec_mode = 2'(mode); ctl_sw_rst = sw;
        cyc(); clear_in();
    endtask

    task automatic kick();
        wd_timeout = 1; cyc(); clear_in();
    endtask

    // Counts low samples starting from the current negedge, adding pre.
    task automatic measure(input string tag, input int pre);
        int n;
        n = pre;
        while (srst_n == 1'b0 && n < 4 * PULSE_LEN) begin
            n++;
            cyc();
        end
        chk(tag, n, PULSE_LEN);
    endtask

    initial begin
        repeat (3) cyc();
        chk("R1 m_active in reset", int'(m_active), M_INIT);
        chk("R1 srst_n in reset", int'(srst_n), 1);
        rst_n = 1;
        cyc();
        chk("R1 m_active", int'(m_active), M_INIT);
        chk("R1 n_active", int'(n_active), N_INIT);
        chk("R1 srst_n", int'(srst_n), 1);
        chk("R1 sw_rst_bit", int'(sw_rst_bit), 0);

        wr_m(77); wr_n(120);
        chk("R2 m_active", int'(m_active), 77);
        chk("R2 n_active", int'(n_active), 120);

        // Mode 00: only the pulse.
        kick();
        chk("R6 srst_n falls", int'(srst_n), 0);
        chk("R5 m held mode 00", int'(m_active), 77);
        chk("R5 n held mode 00", int'(n_active), 120);
        measure("R6 timeout width", 0);

        // Manual mode restore.
        wr_nrec(55);
        wr_ctl(1, 1, 0);
        wr_m(90); wr_n(130);
        kick();
        chk("R4 m restored", int'(m_active), 77);
        chk("R4 n restored", int'(n_active), 55);
        measure("R6 manual width", 0);

        // Enable already set: no second copy.
        wr_m(200);
        wr_ctl(1, 1, 0);
        kick();
        chk("R3 no relatch m", int'(m_active), 77);
        measure("R6 width", 0);

        // Restore wins over a same-edge write.
        wd_timeout = 1; m_wr = 1; m_wdata = 9'd33; n_wr = 1; n_wdata = 8'd44;
        cyc(); clear_in();
        chk("R11 m restore wins", int'(m_active), 77);
        chk("R11 n restore wins", int'(n_active), 55);
        measure("R6 width", 0);

        // Reserved mode 10 behaves as no recovery.
        wr_ctl(1, 2, 0);
        wr_m(150);
        kick();
        chk("R5 m held mode 10", int'(m_active), 150);
        measure("R6 width", 0);

        // Software request waits for end of transaction.
        wr_ctl(1, 0, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R7 no pulse before xact_end", int'(srst_n), 1);
            chk("R7 bit set", int'(sw_rst_bit), 1);
            cyc();
        end
        xact_end = 1; cyc(); clear_in();
        chk("R7 pulse after xact_end", int'(srst_n), 0);
        measure("R8 software width", 0);
        chk("R9 bit cleared at pulse end", int'(sw_rst_bit), 0);

        // Request and end of transaction in the same cycle.
        ctl_wr = 1; ctl_wd_en = 1; ctl_rec_mode = 2'b00; ctl_sw_rst = 1; xact_end = 1;
        cyc(); clear_in();
        chk("R7 same-cycle pulse", int'(srst_n), 0);
        measure("R8 software width", 0);
        chk("R9 bit cleared", int'(sw_rst_bit), 0);

        // Merge: manual mode, second timeout and request during a pulse.
        wr_ctl(1, 1, 0);
        kick();
        chk("R4 m restored again", int'(m_active), 77);
        begin
            int low;
            low = 0;
            for (int i = 0; i < 3; i++) begin low++; cyc(); end
            m_wr = 1; m_wdata = 9'd12; low++; cyc(); clear_in();
            wd_timeout = 1; ctl_wr = 1; ctl_wd_en = 1; ctl_rec_mode = 2'b01;
            ctl_sw_rst = 1; xact_end = 1;
            low++; cyc(); clear_in();
            chk("R10 merged timeout no restore", int'(m_active), 12);
            chk("R9 bit held during pulse", int'(sw_rst_bit), 1);
            measure("R10 merged width", low);
        end
        chk("R9 merged bit cleared", int'(sw_rst_bit), 0);
        chk("R10 no second pulse", int'(srst_n), 1);
        repeat (3) cyc();
        chk("R10 still high", int'(srst_n), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule